// File: doc/BRIEF.md
# PLL Configuration and Lock-Status Register Block

This block is the register-mapped control point for one multiplying digital PLL and two fixed-rate analog PLLs. Software reaches it over a single-cycle register bus: an address, a write strobe, write data and a combinational read-data return. Three configuration registers are kept: a mode register that holds a 2-bit mode for each PLL, a synthesis register that holds the digital PLL's multiplier and divider, and a core-source register that picks what drives the core clock. The analog oscillators and the clock synthesis are outside the block. What it provides is the control state they would follow: per-PLL lock indications, a bypass indication, the core clock mux select, and a packed status word. That word reports which source actually drives the core.

Digital PLL lock is timed. The block clock stands in for the reference, and an internal tick fires once every (divider + 1) reference cycles. The lock indication rises after a fixed number of these ticks, counted from the most recent write that actually changed the PLL's mode, multiplier or divider. A multiplier of 0 or 1 overrides the mode field and keeps the PLL in bypass. Writes that set reserved bits raise a one-cycle error pulse. Illegal mode and source encodings raise a configuration-error level.

Top module: `pll_ctrl_regs`

## Requirements
- R1: After reset the mode register reads 0x0, the synthesis register reads 0x0, the core-source register reads 0x2, the status word (offset 0x520) reads 0x71, core_sel is 2, dpll_bypass is 1, and dpll_locked, apll_locked, cfg_err and err_rsvd are all 0.
- R2: The mode register (offset 0x500) keeps only write-data bits 7:6 (first analog PLL mode), 3:2 (second analog PLL mode) and 1:0 (digital PLL mode). Its readback is the write value ANDed with 0xCF.
- R3: The synthesis register (offset 0x540) stores the write value ANDed with 0x03BFFF28. The multiplier is bits 21:12 and the divider is bits 11:8.
- R4: The core-source register (offset 0x544) stores write bits 1:0. core_sel presents that field and changes only on a write.
- R5: err_rsvd is high for exactly the one cycle after a write that sets any bit in that register's reserved mask: 0xFFFFFF30 at 0x500, 0xFC4000D7 at 0x540, 0xFFFFFFFC at 0x544.
- R6: apll_locked[0] is 1 exactly when mode bits 7:6 equal 3, and apll_locked[1] is 1 exactly when mode bits 3:2 equal 3. The status word reports them at bit 9 and bit 8.
- R7: cfg_err is high while any of these holds: an analog PLL mode field is 1 or 2, the effective digital PLL mode is 0, or the core source is 3.
- R8: When the multiplier is 0 or 1, the effective digital PLL mode is 1 (bypass) whatever bits 1:0 hold. dpll_bypass is 1 and dpll_locked stays 0.
- R9: With effective mode 3, dpll_locked rises exactly 20*(divider+1) clock cycles after the write that restarted the lock timer. It is never high while dpll_bypass is high.
- R10: A write that changes mode bits 1:0 or synthesis bits 21:8 clears dpll_locked on the next cycle and restarts the timer. A write that leaves those bits unchanged, or that changes only the core source, does not disturb an existing lock.
- R11: Status bits 1:0 read 3 when the core source is 0. Otherwise they read 1 when the digital PLL is not locked and 2 when it is locked. Bits 6:4 always read 1.
- R12: Reads of any other offset return 0. Writes to any other offset change no register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the reference for lock timing |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| core_sel | output | 2 | Core clock mux select |
| dpll_locked | output | 1 | Digital PLL lock indication |
| dpll_bypass | output | 1 | Digital PLL is not in lock mode (ratio 1:1) |
| apll_locked | output | 2 | Lock indication, bit 0 first analog PLL, bit 1 second |
| cfg_err | output | 1 | Illegal mode or source encoding present |
| err_rsvd | output | 1 | One-cycle pulse after a write touching reserved bits |

## Verification
Two functions can fall in the same cycle. The first is a lock completing on its last divided-reference tick. The second is a write that either restarts the timer or leaves it alone. The bench provokes both: it rewrites identical synthesis and mode values, and changes only the core source, while a lock is held, and checks that dpll_locked stays up. It then changes the divider and expects dpll_locked to drop on the following cycle and to rise again at the recomputed 20*(divider+1) count. Mixed random writes also set reserved bits and legal fields together. For those, the bench judges the stored value and the error pulse of the same write against its own masked model.

// File: rtl/pll_regs_pkg.sv
package pll_regs_pkg;

  localparam int DATA_W = 32;

  localparam logic [11:0] OFF_MODE   = 12'h500;
  localparam logic [11:0] OFF_STATUS = 12'h520;
  localparam logic [11:0] OFF_SYNTH  = 12'h540;
  localparam logic [11:0] OFF_SRC    = 12'h544;

  localparam logic [31:0] MODE_KEEP  = 32'h0000_00CF;
  localparam logic [31:0] MODE_RSVD  = 32'hFFFF_FF30;
  localparam logic [31:0] SYNTH_KEEP = 32'h03BF_FF28;
  localparam logic [31:0] SYNTH_RSVD = 32'hFC40_00D7;
  localparam logic [31:0] SYNTH_DPLL = 32'h003F_FF00;
  localparam logic [31:0] SRC_KEEP   = 32'h0000_0003;

  localparam int MULT_LSB = 12;
  localparam int MULT_W   = 10;
  localparam int DIV_LSB  = 8;
  localparam int DIV_W    = 4;

  localparam logic [31:0] STATUS_BASE = 32'h0000_0070;

  typedef enum logic [1:0] {
    DM_ILLEGAL = 2'd0,
    DM_LP_BYP  = 2'd1,
    DM_FR_BYP  = 2'd2,
    DM_LOCK    = 2'd3
  } dpll_mode_e;

  typedef enum logic [1:0] {
    SRC_SLOW   = 2'd0,
    SRC_DPLL   = 2'd1,
    SRC_DPLLX2 = 2'd2,
    SRC_BAD    = 2'd3
  } core_src_e;

endpackage

// File: rtl/pll_cfg_regfile.sv
module pll_cfg_regfile
  import pll_regs_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   mode_q,
  output logic [DATA_W-1:0]   synth_q,
  output logic [1:0]          src_q,
  output logic                rsvd_err_q,
  output logic                dpll_restart
);

  logic            hit_mode, hit_synth, hit_src;
  logic            mode_en, synth_en, src_en;
  logic [DATA_W-1:0] mode_d, synth_d;
  logic [1:0]      src_d;
  logic            rsvd_err_d;

  always_comb begin
    hit_mode  = bus_we && (bus_addr == ADDR_W'(OFF_MODE));
    hit_synth = bus_we && (bus_addr == ADDR_W'(OFF_SYNTH));
    hit_src   = bus_we && (bus_addr == ADDR_W'(OFF_SRC));

    mode_d  = bus_wdata & MODE_KEEP;
    synth_d = bus_wdata & SYNTH_KEEP;
    src_d   = bus_wdata[1:0];

    mode_en  = hit_mode  && (mode_d  != mode_q);
    synth_en = hit_synth && (synth_d != synth_q);
    src_en   = hit_src   && (src_d   != src_q);

    dpll_restart = (hit_mode  && (mode_q[1:0] != bus_wdata[1:0])) ||
                   (hit_synth && (((synth_q ^ bus_wdata) & SYNTH_DPLL) != '0));

    rsvd_err_d = (hit_mode  && ((bus_wdata & MODE_RSVD)  != '0)) ||
                 (hit_synth && ((bus_wdata & SYNTH_RSVD) != '0)) ||
                 (hit_src   && ((bus_wdata & ~SRC_KEEP)  != '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= '0;
      synth_q    <= '0;
      src_q      <= SRC_DPLLX2;
      rsvd_err_q <= 1'b0;
    end else begin
      if (mode_en)  mode_q  <= mode_d;
      if (synth_en) synth_q <= synth_d;
      if (src_en)   src_q   <= src_d;
      rsvd_err_q <= rsvd_err_d;
    end
  end

endmodule

// File: rtl/pll_dpll_lock.sv
module pll_dpll_lock
  import pll_regs_pkg::*;
#(
  parameter int M_W        = 10,
  parameter int D_W        = 4,
  parameter int LOCK_TICKS = 20
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           restart,
  input  logic [1:0]     mode_field,
  input  logic [M_W-1:0] mult,
  input  logic [D_W-1:0] div,
  output logic           lock_mode,
  output logic           bypass,
  output logic           mode_err,
  output logic           locked
);

  localparam int CNT_W = $clog2(LOCK_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(LOCK_TICKS);

  dpll_mode_e     eff_mode;
  logic [D_W-1:0] presc_q, presc_d;
  logic [CNT_W-1:0] tick_cnt_q, tick_cnt_d;
  logic           cnt_en;
  logic           tick;

  always_comb begin
    if (mult < M_W'(2)) eff_mode = DM_LP_BYP;
    else                eff_mode = dpll_mode_e'(mode_field);
    lock_mode = (eff_mode == DM_LOCK);
    bypass    = !lock_mode;
    mode_err  = (eff_mode == DM_ILLEGAL);
  end

  always_comb begin
    tick       = (presc_q == div);
    cnt_en     = restart || (lock_mode && (tick_cnt_q != CNT_DONE));
    presc_d    = presc_q;
    tick_cnt_d = tick_cnt_q;
    if (restart) begin
      presc_d    = '0;
      tick_cnt_d = '0;
    end else if (tick) begin
      presc_d    = '0;
      tick_cnt_d = tick_cnt_q + CNT_W'(1);
    end else begin
      presc_d    = presc_q + D_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q    <= '0;
      tick_cnt_q <= '0;
    end else if (cnt_en) begin
      presc_q    <= presc_d;
      tick_cnt_q <= tick_cnt_d;
    end
  end

  assign locked = lock_mode && (tick_cnt_q == CNT_DONE);

endmodule

// File: rtl/pll_status_mux.sv
module pll_status_mux
  import pll_regs_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int NUM_APLL = 2
) (
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   mode_q,
  input  logic [DATA_W-1:0]   synth_q,
  input  logic [1:0]          src_q,
  input  logic [NUM_APLL-1:0] apll_locked,
  input  logic                dpll_locked,
  output logic [DATA_W-1:0]   bus_rdata
);

  logic [DATA_W-1:0] status_word;
  logic [1:0]        core_code;

  always_comb begin
    if (src_q == SRC_SLOW)  core_code = 2'd3;
    else if (!dpll_locked)  core_code = 2'd1;
    else                    core_code = 2'd2;
    status_word = STATUS_BASE;
    status_word[9]   = apll_locked[0];
    status_word[8]   = apll_locked[NUM_APLL-1];
    status_word[1:0] = core_code;
  end

  always_comb begin
    unique case (bus_addr)
      ADDR_W'(OFF_MODE):   bus_rdata = mode_q;
      ADDR_W'(OFF_STATUS): bus_rdata = status_word;
      ADDR_W'(OFF_SYNTH):  bus_rdata = synth_q;
      ADDR_W'(OFF_SRC):    bus_rdata = {{(DATA_W-2){1'b0}}, src_q};
      default:             bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/pll_ctrl_regs.sv
module pll_ctrl_regs
  import pll_regs_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int LOCK_TICKS = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [1:0]        core_sel,
  output logic              dpll_locked,
  output logic              dpll_bypass,
  output logic [1:0]        apll_locked,
  output logic              cfg_err,
  output logic              err_rsvd
);

  localparam int NUM_APLL = 2;

  logic [DATA_W-1:0]   mode_q, synth_q;
  logic [1:0]          src_q;
  logic                dpll_restart;
  logic                lock_mode, dpll_mode_err;
  logic [NUM_APLL-1:0] apll_bad;

  pll_cfg_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_we       (bus_we),
    .bus_wdata    (bus_wdata),
    .mode_q       (mode_q),
    .synth_q      (synth_q),
    .src_q        (src_q),
    .rsvd_err_q   (err_rsvd),
    .dpll_restart (dpll_restart)
  );

  pll_dpll_lock #(
    .M_W        (MULT_W),
    .D_W        (DIV_W),
    .LOCK_TICKS (LOCK_TICKS)
  ) u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (dpll_restart),
    .mode_field (mode_q[1:0]),
    .mult       (synth_q[MULT_LSB +: MULT_W]),
    .div        (synth_q[DIV_LSB +: DIV_W]),
    .lock_mode  (lock_mode),
    .bypass     (dpll_bypass),
    .mode_err   (dpll_mode_err),
    .locked     (dpll_locked)
  );

  // first analog PLL mode sits at bits 7:6, second at bits 3:2
  for (genvar gi = 0; gi < NUM_APLL; gi++) begin : g_apll
    localparam int LSB = 6 - 4 * gi;
    logic [1:0] fld;
    assign fld            = mode_q[LSB +: 2];
    assign apll_locked[gi] = (fld == 2'd3);
    assign apll_bad[gi]    = (fld == 2'd1) || (fld == 2'd2);
  end

  pll_status_mux #(.ADDR_W(ADDR_W), .NUM_APLL(NUM_APLL)) u_stat (
    .bus_addr    (bus_addr),
    .mode_q      (mode_q),
    .synth_q     (synth_q),
    .src_q       (src_q),
    .apll_locked (apll_locked),
    .dpll_locked (dpll_locked),
    .bus_rdata   (bus_rdata)
  );

  assign core_sel = src_q;
  assign cfg_err  = (|apll_bad) || dpll_mode_err || (src_q == SRC_BAD);

endmodule

// File: rtl/pll_ctrl_regs_chk.sv
module pll_ctrl_regs_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic              dpll_locked,
  input logic              dpll_bypass,
  input logic [1:0]        apll_locked,
  input logic              err_rsvd,
  input logic [1:0]        core_sel,
  input logic              dpll_restart,
  input logic [31:0]       synth_q
);

  p_lock_not_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dpll_locked |-> !dpll_bypass);

  p_restart_unlock_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dpll_restart |=> !dpll_locked);

  p_lock_rise_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dpll_locked) |-> !$past(dpll_restart));

  p_apll_by_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (apll_locked != $past(apll_locked)) |-> $past(bus_we));

  p_rsvd_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_rsvd |-> $past(bus_we));

  p_src_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_we) |-> $stable(core_sel));

  p_small_mult_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (synth_q[21:12] < 10'd2) |-> (dpll_bypass && !dpll_locked));

endmodule

bind pll_ctrl_regs pll_ctrl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_we       (bus_we),
  .dpll_locked  (dpll_locked),
  .dpll_bypass  (dpll_bypass),
  .apll_locked  (apll_locked),
  .err_rsvd     (err_rsvd),
  .core_sel     (core_sel),
  .dpll_restart (dpll_restart),
  .synth_q      (synth_q)
);

// File: tb/pll_ctrl_regs_bench.sv
module pll_ctrl_regs_bench;

  logic        clk;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [1:0]  core_sel;
  logic        dpll_locked, dpll_bypass, cfg_err, err_rsvd;
  logic [1:0]  apll_locked;

  int n_run  = 0;
  int n_fail = 0;

  logic [31:0] m_mode, m_synth;
  logic [1:0]  m_src;

  pll_ctrl_regs u_pll_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_sel(core_sel),
    .dpll_locked(dpll_locked), .dpll_bypass(dpll_bypass),
    .apll_locked(apll_locked), .cfg_err(cfg_err), .err_rsvd(err_rsvd)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] keep_of(input logic [11:0] a);
    case (a)
      12'h500: return 32'h0000_00CF;
      12'h540: return 32'h03BF_FF28;
      12'h544: return 32'h0000_0003;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] rsvd_of(input logic [11:0] a);
    case (a)
      12'h500: return 32'hFFFF_FF30;
      12'h540: return 32'hFC40_00D7;
      12'h544: return 32'hFFFF_FFFC;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic exp_cfg_err(input logic [31:0] md, input logic [31:0] sy, input logic [1:0] sr);
    logic [1:0] a0, a1, dm;
    a0 = md[7:6]; a1 = md[3:2];
    dm = (sy[21:12] < 10'd2) ? 2'd1 : md[1:0];
    return (a0 == 2'd1) || (a0 == 2'd2) || (a1 == 2'd1) || (a1 == 2'd2) ||
           (dm == 2'd0) || (sr == 2'd3);
  endfunction

  function automatic logic [31:0] exp_status(input logic [31:0] md, input logic [1:0] sr, input logic lk);
    logic [31:0] s;
    s = 32'h70;
    s[9] = (md[7:6] == 2'd3);
    s[8] = (md[3:2] == 2'd3);
    s[1:0] = (sr == 2'd0) ? 2'd3 : (lk ? 2'd2 : 2'd1);
    return s;
  endfunction

  // write task: drive at negedge, capture at posedge, return at following negedge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
    case (a)
      12'h500: m_mode  = d & 32'hCF;
      12'h540: m_synth = d & 32'h03BF_FF28;
      12'h544: m_src   = d[1:0];
      default: ;
    endcase
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic chk_regs(input string tag);
    logic [31:0] v;
    rd(12'h500, v); chk({tag, " mode"}, v, m_mode);
    rd(12'h540, v); chk({tag, " synth"}, v, m_synth);
    rd(12'h544, v); chk({tag, " src"}, v, {30'd0, m_src});
  endtask

  // wait N cycles after a restarting write; check low at N-1, high at N
  task automatic lock_window(input int n, input string tag);
    repeat (n - 1) @(posedge clk);
    @(negedge clk);
    chk({tag, " still unlocked at N-1"}, {31'd0, dpll_locked}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk({tag, " locked at N"}, {31'd0, dpll_locked}, 32'd1);
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    m_mode = 0; m_synth = 0; m_src = 2'd2;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_regs("R1 reset");
    rd(12'h520, v); chk("R1 status", v, 32'h71);
    chk("R1 core_sel", {30'd0, core_sel}, 32'd2);
    chk("R1 bypass", {31'd0, dpll_bypass}, 32'd1);
    chk("R1 flags", {27'd0, dpll_locked, apll_locked, cfg_err, err_rsvd}, 32'd0);

    // R2 R5 R6 R8: all ones to mode reg, multiplier still 0
    wr(12'h500, 32'hFFFF_FFFF);
    rd(12'h500, v); chk("R2 mode mask", v, 32'hCF);
    chk("R5 mode rsvd pulse", {31'd0, err_rsvd}, 32'd1);
    chk("R6 both apll locked", {30'd0, apll_locked}, 32'd3);
    rd(12'h520, v); chk("R6 status bits 9:8", v, 32'h371);
    repeat (45) @(posedge clk);
    @(negedge clk);
    chk("R5 pulse gone", {31'd0, err_rsvd}, 32'd0);
    chk("R8 mult0 no lock", {30'd0, dpll_locked, dpll_bypass}, 32'd1);
    chk("R8 mult0 no err", {31'd0, cfg_err}, 32'd0);

    // R7 illegal analog modes
    wr(12'h500, 32'h44);
    chk("R7 apll mode 1 err", {31'd0, cfg_err}, 32'd1);
    chk("R6 apll unlocked", {30'd0, apll_locked}, 32'd0);

    // R9 lock with div 1 (N = 40)
    wr(12'h540, (32'd5 << 12) | (32'd1 << 8));
    chk("R7 dpll mode0 err", {31'd0, cfg_err}, 32'd1);
    wr(12'h500, 32'hCF);
    chk("R9 lock mode", {31'd0, dpll_bypass}, 32'd0);
    lock_window(40, "R9 div1");
    rd(12'h520, v); chk("R11 locked dpll code", v, 32'h372);

    // R10 identical rewrites and source change keep lock
    wr(12'h500, 32'hCF);
    wr(12'h540, (32'd5 << 12) | (32'd1 << 8) | 32'h20);
    wr(12'h544, 32'h1);
    chk("R4 core_sel follows", {30'd0, core_sel}, 32'd1);
    chk("R10 lock held", {31'd0, dpll_locked}, 32'd1);

    // R10 divider change restarts (N = 20)
    wr(12'h540, (32'd5 << 12));
    chk("R10 cleared after change", {31'd0, dpll_locked}, 32'd0);
    lock_window(20, "R10 relock div0");

    // R11 slow source and R7 bad source, R5 src reserved
    wr(12'h544, 32'h0);
    rd(12'h520, v); chk("R11 slow source code", v, 32'h373);
    wr(12'h544, 32'h3);
    chk("R7 src 3 err", {31'd0, cfg_err}, 32'd1);
    wr(12'h544, 32'h6);
    chk("R5 src rsvd pulse", {31'd0, err_rsvd}, 32'd1);
    rd(12'h544, v); chk("R4 src stored", v, 32'h2);

    // R3 synth mask and reserved
    wr(12'h540, 32'hFFFF_FFFF);
    rd(12'h540, v); chk("R3 synth mask", v, 32'h03BF_FF28);
    chk("R5 synth rsvd pulse", {31'd0, err_rsvd}, 32'd1);

    // R12 unmapped
    wr(12'h504, 32'hFFFF_FFFF);
    rd(12'h504, v); chk("R12 unmapped read", v, 32'h0);
    chk("R12 no rsvd pulse", {31'd0, err_rsvd}, 32'd0);
    chk_regs("R12 regs unchanged");

    // R8 mult 1 in lock mode
    wr(12'h540, (32'd1 << 12));
    repeat (50) @(posedge clk);
    @(negedge clk);
    chk("R8 mult1 bypass", {30'd0, dpll_locked, dpll_bypass}, 32'd1);

    // random mixed writes
    for (int i = 0; i < 300; i++) begin
      logic [11:0] a;
      logic [31:0] d;
      logic        exp_r;
      case ($urandom % 5)
        0: a = 12'h500;
        1: a = 12'h540;
        2: a = 12'h544;
        3: a = 12'h520;
        default: a = 12'h548;
      endcase
      d = $urandom;
      if ($urandom % 2) d = d & keep_of(a);
      exp_r = (d & rsvd_of(a)) != 0;
      wr(a, d);
      chk("R5 random rsvd", {31'd0, err_rsvd}, {31'd0, exp_r});
      chk("R7 random cfg_err", {31'd0, cfg_err}, {31'd0, exp_cfg_err(m_mode, m_synth, m_src)});
      chk("R6 random apll", {30'd0, apll_locked},
          {30'd0, m_mode[3:2] == 2'd3, m_mode[7:6] == 2'd3});
      chk("R4 random core_sel", {30'd0, core_sel}, {30'd0, m_src});
      rd(12'h520, v);
      chk("R11 random status", v, exp_status(m_mode, m_src, dpll_locked));
      if (i % 10 == 0) chk_regs("R2 R3 R12 random regs");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule